// File: doc/BRIEF.md
# Switch-Gated Cumulative Lamp Sequencer

This block steps a row of lamp groups through a repeating build-up pattern. It has one state per step. From the dark step, each clock edge lights one more group: the first group alone, then the first two, then all of them, and then the row goes dark again. The machine is Moore style. The lit set is decoded from the step register alone and then gated by a main switch, so no lamp is ever lit while the switch is off.

The step register changes on every clock edge. While the switch is on it moves forward one step, wrapping from the full step back to the dark step. While the switch is off it falls back to the dark step, so each time the switch is turned on the pattern starts again from the beginning. A synchronous reset also forces the dark step. The current step is brought out for observation. With the default of three groups the step is a two-bit value with these meanings: 0 is all dark, 1 is group 1 lit, 2 is groups 1 and 2 lit, and 3 is all three lit.

Top module: `lamp_seq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `step_q` is 0 after that edge.
- R2: While `sw_on` is high and `rst` is low at a rising edge, `step_q` advances by one: 0 to 1, 1 to 2, 2 to 3, and 3 back to 0.
- R3: While `sw_on` is low and `rst` is low at a rising edge, `step_q` is 0 after that edge, whatever its value before.
- R4: `lamp_en[0]` is high exactly when `sw_on` is high and `step_q` is 1, 2 or 3.
- R5: `lamp_en[1]` is high exactly when `sw_on` is high and `step_q` is 2 or 3.
- R6: `lamp_en[2]` is high exactly when `sw_on` is high and `step_q` is 3.
- R7: While `sw_on` is low, `lamp_en` is all zero in every step, in the same cycle.
- R8: In the first cycle in which `sw_on` is high after a cycle in which it was low, `step_q` is 0. The lit pattern then runs again from the first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Main switch; high means on |
| lamp_en | output | 3 | Lamp-group enables; bit g drives group g+1 |
| step_q | output | 2 | Current step of the sequence |

## Verification
The hardest case to reach is turning the switch off while the machine is in step 2 or step 3. The machine only gets there after two or three switch-on cycles in a row, so evenly split random stimulus seldom lands there. The bench therefore runs a directed sweep: from a restart it holds the switch on for k cycles, for k from 0 to 4, and then drops it, checking both that the lamps go dark in that same cycle and that the step returns to zero. The random phase keeps the switch on about 80% of the time, so that long runs and wraps happen often, and it adds occasional resets in the middle of a run.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;

  // One step of the sequence, in plain integers so that any caller may
  // restate or reuse it independently of the register width.
  function automatic int unsigned seq_advance(input int unsigned cur,
                                              input bit on,
                                              input int unsigned last);
    if (!on)              return 0;
    else if (cur >= last) return 0;
    else                  return cur + 1;
  endfunction

  // Group g is lit in every step beyond g when the switch is on.
  function automatic bit group_lit(input int unsigned step,
                                   input int unsigned g,
                                   input bit on);
    return on && (step > g);
  endfunction

endpackage

// File: rtl/lamp_seq_next.sv
module lamp_seq_next #(
  parameter int unsigned NUM_GROUPS = 3,
  localparam int unsigned SW = $clog2(NUM_GROUPS + 1)
) (
  input  logic [SW-1:0] cur_step,
  input  logic          sw_on,
  output logic [SW-1:0] nxt_step,
  output logic          wrap_evt
);
  import lamp_seq_pkg::*;

  always_comb begin
    nxt_step = SW'(seq_advance(32'(cur_step), sw_on, NUM_GROUPS));
    wrap_evt = sw_on && (cur_step == SW'(NUM_GROUPS));
  end
endmodule

// File: rtl/lamp_seq_state.sv
module lamp_seq_state #(
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/lamp_seq_decode.sv
module lamp_seq_decode #(
  parameter int unsigned NUM_GROUPS = 3,
  localparam int unsigned SW = $clog2(NUM_GROUPS + 1)
) (
  input  logic [SW-1:0]         step,
  input  logic                  sw_on,
  output logic [NUM_GROUPS-1:0] lamp_en
);
  import lamp_seq_pkg::*;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign lamp_en[g] = group_lit(32'(step), g, sw_on);
  end
endmodule

// File: rtl/lamp_seq_top.sv
module lamp_seq_top #(
  parameter int unsigned NUM_GROUPS = 3,
  localparam int unsigned SW = $clog2(NUM_GROUPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sw_on,
  output logic [NUM_GROUPS-1:0] lamp_en,
  output logic [SW-1:0]         step_q
);
  logic [SW-1:0] nxt_step;
  logic          wrap_evt;   // named event for the checker: full step ends

  lamp_seq_next #(.NUM_GROUPS(NUM_GROUPS)) u_next (
    .cur_step (step_q),
    .sw_on    (sw_on),
    .nxt_step (nxt_step),
    .wrap_evt (wrap_evt)
  );

  lamp_seq_state #(.SW(SW)) u_state (
    .clk (clk),
    .rst (rst),
    .d   (nxt_step),
    .q   (step_q)
  );

  lamp_seq_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .step    (step_q),
    .sw_on   (sw_on),
    .lamp_en (lamp_en)
  );
endmodule

// File: rtl/lamp_seq_chk.sv
module lamp_seq_chk #(
  parameter int unsigned NUM_GROUPS = 3,
  localparam int unsigned SW = $clog2(NUM_GROUPS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sw_on,
  input logic [NUM_GROUPS-1:0] lamp_en,
  input logic [SW-1:0]         step_q,
  input logic                  wrap_evt
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> step_q == '0);

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (sw_on && !wrap_evt) |=> step_q == $past(step_q) + SW'(1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> step_q == '0);

  assert_off_clears_R3: assert property (@(posedge clk) disable iff (rst)
    !sw_on |=> step_q == '0);

  assert_first_lit_R4: assert property (@(posedge clk) disable iff (rst)
    lamp_en[0] |-> (sw_on && step_q != '0));

  if (NUM_GROUPS >= 3) begin : g_three
    assert_second_lit_R5: assert property (@(posedge clk) disable iff (rst)
      lamp_en[1] |-> (sw_on && step_q >= SW'(2)));
    assert_third_lit_R6: assert property (@(posedge clk) disable iff (rst)
      lamp_en[2] |-> (sw_on && step_q == SW'(3)));
  end

  assert_dark_off_R7: assert property (@(posedge clk) disable iff (rst)
    !sw_on |-> $countones(lamp_en) == 0);

  assert_cumulative_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(lamp_en) == (sw_on ? int'(step_q) : 0));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_on) |-> step_q == '0);
endmodule

bind lamp_seq_top lamp_seq_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sw_on    (sw_on),
  .lamp_en  (lamp_en),
  .step_q   (step_q),
  .wrap_evt (wrap_evt)
);

// File: tb/test_lamp_seq_top.sv
module test_lamp_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_on = 1'b0;
  logic [2:0] lamp_en;
  logic [1:0] step_q;

  int vectors = 0;
  int miscompares = 0;
  int exp_step = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lamp_seq_top i_lamp_seq_top (
    .clk     (clk),
    .rst     (rst),
    .sw_on   (sw_on),
    .lamp_en (lamp_en),
    .step_q  (step_q)
  );

  // Bench model: lamp count equals the step when the switch is on.
  function automatic logic [2:0] model_lamps(int step, bit on);
    logic [2:0] m;
    m = 3'b000;
    if (on) begin
      if (step >= 1) m[0] = 1'b1;
      if (step >= 2) m[1] = 1'b1;
      if (step == 3) m[2] = 1'b1;
    end
    return m;
  endfunction

  function automatic int model_next(int step, bit r, bit on);
    if (r || !on) return 0;
    return (step + 1) % 4;
  endfunction

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Drive at the falling edge, check after settling, then advance the model
  // across the next rising edge.
  task automatic apply(bit r, bit on);
    @(negedge clk);
    rst = r;
    sw_on = on;
    #1;
    check("R2/R3 step", int'(step_q), exp_step);
    if (!on) check("R7 dark", int'(lamp_en), 0);
    else if (exp_step == 3) check("R6 all lit", int'(lamp_en), int'(model_lamps(exp_step, on)));
    else if (exp_step == 2) check("R5 two lit", int'(lamp_en), int'(model_lamps(exp_step, on)));
    else check("R4 first lit", int'(lamp_en), int'(model_lamps(exp_step, on)));
    exp_step = model_next(exp_step, r, on);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    // R1: reset state
    apply(1'b1, 1'b1);
    apply(1'b1, 1'b1);
    @(negedge clk); #1;
    check("R1 reset step", int'(step_q), 0);
    // R2: full cycle twice with switch on
    for (int i = 0; i < 9; i++) apply(1'b0, 1'b1);
    // R3/R7/R8: drop the switch after k on cycles in every step
    for (int k = 0; k <= 4; k++) begin
      apply(1'b0, 1'b0);
      for (int j = 0; j < k; j++) apply(1'b0, 1'b1);
      apply(1'b0, 1'b0);
      @(negedge clk); #1;
      check("R3 cleared", int'(step_q), 0);
      exp_step = 0;
      // R8: restart sees step 0 in its first on cycle
      apply(1'b0, 1'b1);
      apply(1'b0, 1'b1);
      check("R8 restart lit one", int'(lamp_en), 1);
    end
    // Random phase: switch on about 80%, rare resets
    for (int i = 0; i < 400; i++) begin
      bit on;
      bit r;
      on = ($urandom % 10) < 8;
      r  = ($urandom % 32) == 0;
      apply(r, on);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule